// File: doc/BRIEF.md
# Weekly Minute Alarm Comparator

The block holds an alarm setting made of a BCD minute, a BCD hour and a seven-bit weekday mask. It watches the calendar time that a neighbouring counter supplies. Each time the counter signals the start of a new minute, the block compares the current minute, hour and weekday against that setting. On a match, with the alarm enabled, it sets an interrupt flag. The flag drives a level interrupt and stays set until software clears it.

The alarm has one-minute resolution. Only the day of the week is matched, so an alarm can be at most one week ahead. Because the day is a mask and not a single value, one setting can fire at the same time of day on several days.

Software reaches the block through a simple byte-wide register port with combinational read data. The start-of-minute input is edge-detected, so a strobe held high for many cycles counts as one evaluation.

Top module: `wkalarm_cmp`

## Requirements
- R1: After reset `irq_o` is 0, and every register reads back 0.
- R2: Register map, byte-wide:
  - Offset 0x40 holds the alarm minute (BCD, 8 bits).
  - Offset 0x44 holds the alarm hour (BCD, 8 bits).
  - Offset 0x48 holds the weekday mask in bits 6:0, where bit n selects weekday code n. Bit 7 reads 0.
  - Offset 0x04 is the control register. Bit 4 is the alarm enable and the other bits read 0.
  - Offset 0x0C bit 0 reads the interrupt flag.
  - Reads of any other offset return 0.
- R3: When the alarm is enabled and a rising edge of `sec_zero_i` arrives with `cur_min_i` and `cur_hour_i` equal to the alarm minute and hour, and with the mask bit of `cur_wday_i` set, `irq_o` is 1 from the following clock edge.
- R4: A mismatch in the minute, in the hour, or in the weekday mask bit leaves the flag clear.
- R5: With the enable at 0 (including after a write of 0 to offset 0x04), a matching minute does not set the flag.
- R6: A `sec_zero_i` held high for many cycles causes at most one set. A clear made while the strobe is still high is not undone.
- R7: The flag stays 1 until a write with bit 0 set to offset 0x0C. A write with bit 0 at 0 leaves the flag unchanged.
- R8: A mask with several bits set fires on each selected weekday.
- R9: Weekday code 7 never matches.
- R10: If a match and a clear write fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| cur_min_i | input | 8 | Current BCD minute from the calendar counter |
| cur_hour_i | input | 8 | Current BCD hour from the calendar counter |
| cur_wday_i | input | 3 | Current weekday code, 0 to 6 |
| sec_zero_i | input | 1 | High while the seconds count is 0 |
| irq_o | output | 1 | Level alarm interrupt |

## Verification
The bench aims at the edges of the match rule:
- Near misses, where the minute, the hour or the weekday bit is off by one. A comparator that checked only some fields would fire on these.
- A strobe held high after a clear. A level-sensitive compare would fire again at once here.
- Clear and match in the same cycle. Giving the clear priority would lose that alarm.
- Weekday code 7 against a full mask. An unchecked index would wrap onto a real day.
- Matches while the alarm is disabled. A flag gated only at the output would leave a hidden pending event.

// File: rtl/wkalarm_pkg.sv
package wkalarm_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned AW      = 8;
  localparam int unsigned DAYS    = 7;
  localparam int unsigned DAY_W   = 3;
  localparam int unsigned EN_BIT  = 4;
  localparam logic [AW-1:0] OFS_CTRL = 8'h04;
  localparam logic [AW-1:0] OFS_FLAG = 8'h0C;
  localparam logic [AW-1:0] OFS_AMIN = 8'h40;
  localparam logic [AW-1:0] OFS_AHR  = 8'h44;
  localparam logic [AW-1:0] OFS_AWD  = 8'h48;

  typedef struct packed {
    logic            en;
    logic [DW-1:0]   min;
    logic [DW-1:0]   hour;
    logic [DAYS-1:0] mask;
  } alarm_cfg_t;
endpackage

// File: rtl/wkalarm_regs.sv
module wkalarm_regs
  import wkalarm_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          flag_i,
  output logic [DW-1:0] rdata_o,
  output alarm_cfg_t    cfg_o,
  output logic          clr_o
);
  alarm_cfg_t cfg_q, cfg_d;
  logic       cfg_we;

  always_comb begin
    cfg_d  = cfg_q;
    cfg_we = 1'b0;
    if (wr_en_i) begin
      unique case (addr_i)
        OFS_CTRL: begin cfg_d.en   = wdata_i[EN_BIT];   cfg_we = 1'b1; end
        OFS_AMIN: begin cfg_d.min  = wdata_i;           cfg_we = 1'b1; end
        OFS_AHR:  begin cfg_d.hour = wdata_i;           cfg_we = 1'b1; end
        OFS_AWD:  begin cfg_d.mask = wdata_i[DAYS-1:0]; cfg_we = 1'b1; end
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  assign clr_o = wr_en_i && (addr_i == OFS_FLAG) && wdata_i[0];
  assign cfg_o = cfg_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL: rdata_o[EN_BIT]     = cfg_q.en;
      OFS_FLAG: rdata_o[0]          = flag_i;
      OFS_AMIN: rdata_o             = cfg_q.min;
      OFS_AHR:  rdata_o             = cfg_q.hour;
      OFS_AWD:  rdata_o[DAYS-1:0]   = cfg_q.mask;
      default:  ;
    endcase
  end

  // R5
  en_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_CTRL && !wdata_i[EN_BIT]) |=> !cfg_o.en);
endmodule

// File: rtl/wkalarm_match.sv
module wkalarm_match
  import wkalarm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  alarm_cfg_t       cfg_i,
  input  logic [DW-1:0]    cur_min_i,
  input  logic [DW-1:0]    cur_hour_i,
  input  logic [DAY_W-1:0] cur_wday_i,
  input  logic             sec_zero_i,
  input  logic             clr_i,
  output logic             flag_o
);
  logic sz_q;
  logic flag_q, flag_d;
  logic day_hit, hit;

  // Index guard: codes at or above DAYS never select a mask bit.
  always_comb begin
    day_hit = 1'b0;
    for (int d = 0; d < DAYS; d++)
      if (cur_wday_i == DAY_W'(d)) day_hit = cfg_i.mask[d];
  end

  assign hit = cfg_i.en && sec_zero_i && !sz_q && day_hit &&
               (cur_min_i == cfg_i.min) && (cur_hour_i == cfg_i.hour);

  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (hit)   flag_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sz_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      sz_q   <= sec_zero_i;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // R3
  set_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(sec_zero_i && !sz_q));
  // R5
  set_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(cfg_i.en));
  // R6
  once_per_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && sz_q && !sec_zero_i) |=> !flag_q);
  // R7
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  // R9
  bad_day_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && cur_wday_i == 3'd7) |=> !flag_q);
endmodule

// File: rtl/wkalarm_cmp.sv
module wkalarm_cmp
  import wkalarm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [DW-1:0]    cur_min_i,
  input  logic [DW-1:0]    cur_hour_i,
  input  logic [DAY_W-1:0] cur_wday_i,
  input  logic             sec_zero_i,
  output logic             irq_o
);
  alarm_cfg_t cfg;
  logic       clr, flag;

  wkalarm_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .flag_i(flag), .rdata_o, .cfg_o(cfg), .clr_o(clr)
  );

  wkalarm_match u_match (
    .clk_i, .rst_ni, .cfg_i(cfg), .cur_min_i, .cur_hour_i, .cur_wday_i,
    .sec_zero_i, .clr_i(clr), .flag_o(flag)
  );

  assign irq_o = flag;

  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && sec_zero_i && !$past(sec_zero_i) && cfg.en && cur_wday_i < 3'd7 &&
     cfg.mask[cur_wday_i] && cur_min_i == cfg.min && cur_hour_i == cfg.hour) |=> irq_o);
endmodule

// File: tb/wkalarm_cmp_test.sv
module wkalarm_cmp_test;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic [7:0] cmin = 0, chr = 0;
  logic [2:0] cwd = 0;
  logic       sz = 0, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wkalarm_cmp uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cur_min_i(cmin), .cur_hour_i(chr), .cur_wday_i(cwd),
    .sec_zero_i(sz), .irq_o(irq)
  );

  logic [7:0] m_min, m_hr, m_mask;
  bit         m_en;

  function automatic bit exp_hit(bit en, logic [7:0] amin, logic [7:0] ahr, logic [7:0] mask,
                                 logic [7:0] mn, logic [7:0] hr, logic [2:0] wd);
    return en && amin == mn && ahr == hr && wd != 3'd7 && mask[wd];
  endfunction

  function automatic logic [7:0] rbcd(int lim);
    int v = $urandom_range(lim - 1);
    return 8'((v / 10) * 16 + v % 10);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [7:0] exp);
    @(negedge clk); addr = a; #1; chk(req, rdata, exp);
  endtask

  task automatic cfg(bit en, logic [7:0] mn, logic [7:0] hr, logic [7:0] mask);
    wr(8'h40, mn); wr(8'h44, hr); wr(8'h48, mask); wr(8'h04, en ? 8'h10 : 8'h00);
    m_en = en; m_min = mn; m_hr = hr; m_mask = mask;
  endtask

  // one strobe pulse with given time; irq sampled one edge later
  task automatic minute(string req, logic [7:0] mn, logic [7:0] hr, logic [2:0] wd, bit exp);
    @(negedge clk); cmin = mn; chr = hr; cwd = wd; sz = 1;
    @(negedge clk); sz = 0; chk(req, 8'(irq), 8'(exp));
    if (irq) wr(8'h0C, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    chk("R1 irq", 8'(irq), 8'h0);
    rd("R1 ctrl", 8'h04, 8'h00); rd("R1 amin", 8'h40, 8'h00);
    rd("R1 ahr", 8'h44, 8'h00); rd("R1 mask", 8'h48, 8'h00);
    // R2
    wr(8'h04, 8'hFF); rd("R2 ctrl", 8'h04, 8'h10);
    wr(8'h48, 8'hFF); rd("R2 mask", 8'h48, 8'h7F);
    wr(8'h40, 8'h59); rd("R2 amin", 8'h40, 8'h59);
    wr(8'h44, 8'h23); rd("R2 ahr", 8'h44, 8'h23);
    rd("R2 other", 8'h10, 8'h00);
    // R3 / R4
    cfg(1, 8'h30, 8'h07, 8'h08);
    minute("R3 match", 8'h30, 8'h07, 3'd3, 1);
    rd("R7 cleared", 8'h0C, 8'h00);
    minute("R4 min", 8'h31, 8'h07, 3'd3, 0);
    minute("R4 hour", 8'h30, 8'h08, 3'd3, 0);
    minute("R4 day", 8'h30, 8'h07, 3'd2, 0);
    // R5
    wr(8'h04, 8'h00);
    minute("R5 disabled", 8'h30, 8'h07, 3'd3, 0);
    // R7
    wr(8'h04, 8'h10);
    @(negedge clk); cmin = 8'h30; chr = 8'h07; cwd = 3'd3; sz = 1;
    @(negedge clk); chk("R3 irq", 8'(irq), 8'h1);
    wr(8'h0C, 8'h00); chk("R7 hold", 8'(irq), 8'h1);
    rd("R2 flag", 8'h0C, 8'h01);
    // R6: strobe still high, clear must stick
    wr(8'h0C, 8'h01); repeat (4) @(negedge clk);
    chk("R6 once", 8'(irq), 8'h0);
    sz = 0;
    // R8
    cfg(1, 8'h00, 8'h12, 8'h41);
    minute("R8 day0", 8'h00, 8'h12, 3'd0, 1);
    minute("R8 day6", 8'h00, 8'h12, 3'd6, 1);
    minute("R8 day1", 8'h00, 8'h12, 3'd1, 0);
    // R9
    cfg(1, 8'h00, 8'h12, 8'h7F);
    minute("R9 code7", 8'h00, 8'h12, 3'd7, 0);
    // R10: clear and match in the same cycle
    @(negedge clk); cmin = 8'h00; chr = 8'h12; cwd = 3'd2; sz = 1;
    wr_en = 1; addr = 8'h0C; wdata = 8'h01;
    @(negedge clk); wr_en = 0; sz = 0; chk("R10 set wins", 8'(irq), 8'h1);
    wr(8'h0C, 8'h01);
    // random R3/R4
    void'($urandom(32'h5EED));
    for (int i = 0; i < 300; i++) begin
      logic [7:0] mn, hr; logic [2:0] wd;
      cfg($urandom_range(3) != 0, rbcd(60), rbcd(24), 8'($urandom_range(127)));
      mn = ($urandom_range(1)) ? m_min : rbcd(60);
      hr = ($urandom_range(1)) ? m_hr : rbcd(24);
      wd = 3'($urandom_range(7));
      minute("R3/R4 random", mn, hr, wd, exp_hit(m_en, m_min, m_hr, m_mask, mn, hr, wd));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule